// File: doc/BRIEF.md
# Dual-Line Activity Watchdog with Modem Restart

This block watches the transmit and receive data lines of a modem link. Each line has its own retriggerable timer. Every level change on a line reloads that line's timer to its full length and holds the line's activity flag high. When a line stays quiet for longer than the timeout, its flag drops. That tells the host the connection is dead.

A flag that drops also fires a non-retriggerable one-shot. The one-shot drives a shutdown output for a fixed number of cycles, and that output disables or power-cycles the modem so the system can start over. The line inputs are asynchronous, so each one passes through a synchronizer before edge detection. The timeout and the pulse length are parameters counted in clock cycles. The default timeout is about two minutes at 25 MHz. A polarity parameter sets whether the shutdown output is active high or active low.

Top module: `line_activity_watchdog`

## Requirements
- R1: While rst_ni is low, both activity flags are 0 and the shutdown output is inactive: 0 when SHUTDOWN_ACTIVE_HIGH=1, 1 when it is 0.
- R2: Each line input passes through a two-stage synchronizer. A level change driven between rising edges n and n+1 is detected at edge n+3, and that line's activity flag is 1 after that edge.
- R3: With no later detected change, an activity flag stays 1 for exactly TIMEOUT_CYCLES cycles after the detection edge and is 0 from then on.
- R4: Every detected change reloads the full TIMEOUT_CYCLES period, including a change detected in the final cycle of the period. Changes one cycle apart are each detected.
- R5: The two lines are independent. Activity on one line has no effect on the other line's flag.
- R6: When an activity flag falls at edge m and no pulse is running, the shutdown output is active from edge m+1 for exactly SHUTDOWN_CYCLES cycles. If both flags fall at the same edge, one pulse results.
- R7: The shutdown pulse cannot be retriggered. A flag that falls while the pulse is active, including in its last cycle, neither lengthens the pulse nor starts a second one.
- R8: The synchronizer flops reset to IDLE_LEVEL (default 1). Lines held at that level since reset produce no activity and no shutdown pulse.
- R9: With SHUTDOWN_ACTIVE_HIGH=0, the shutdown output is the exact inverse of the active-high form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_line_i | input | 1 | Transmit data line, asynchronous |
| rx_line_i | input | 1 | Receive data line, asynchronous |
| tx_active_o | output | 1 | Transmit line activity flag |
| rx_active_o | output | 1 | Receive line activity flag |
| shutdown_o | output | 1 | Modem shutdown pulse, polarity set by SHUTDOWN_ACTIVE_HIGH |

## Verification
The assertions assume that each line input changes at most once per clock cycle and that the lines rest at IDLE_LEVEL while reset is held. If either assumption fails, the one-cycle change pulses and the reload behaviour they check have no meaning. The stimulus drives the lines only on falling clock edges, with at most one toggle per line per cycle, and keeps both lines at the idle level through reset. The bench runs a short configuration: a 20-cycle timeout and a 12-cycle pulse. Its toggle density sweeps from every cycle to long silences, so flags fall alone, together, and during and at the end of a running pulse.

// File: rtl/lw_pkg.sv
package lw_pkg;
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_TX   = 0;
  localparam int unsigned LINE_RX   = 1;

  function automatic int unsigned cnt_width(input longint unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lw_line_sync.sv
module lw_line_sync #(
  parameter int unsigned STAGES     = 2,
  parameter logic        IDLE_LEVEL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{IDLE_LEVEL}};
      prev_q <= IDLE_LEVEL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/lw_retrig_timer.sv
module lw_retrig_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic active_o,
  output logic expire_o
);
  localparam int unsigned W = lw_pkg::cnt_width(TIMEOUT_CYCLES);
  localparam logic [W-1:0] RELOAD = W'(TIMEOUT_CYCLES - 1);

  logic [W-1:0] cnt_q;
  logic         active_q, expire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (edge_i) begin
        active_q <= 1'b1;
        cnt_q    <= RELOAD;
      end else if (active_q) begin
        if (cnt_q == '0) begin
          active_q <= 1'b0;
          expire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
  assign expire_o = expire_q;

  // R4
  reload_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> active_q && !expire_q);
  // R3
  fall_flags_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> expire_q);
  // R3
  expiry_after_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_q |-> $past(active_q) && $past(cnt_q) == '0);
endmodule

// File: rtl/lw_oneshot.sv
module lw_oneshot #(
  parameter int unsigned PULSE_CYCLES = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o
);
  localparam int unsigned W = lw_pkg::cnt_width(PULSE_CYCLES);
  localparam logic [W-1:0] LOAD = W'(PULSE_CYCLES - 1);

  logic [W-1:0] cnt_q;
  logic         busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (trig_i) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end
  end

  assign busy_o = busy_q;

  // R6
  start_needs_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(trig_i));
  // R7
  no_retrigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 |=> busy_q && cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/line_activity_watchdog.sv
module line_activity_watchdog #(
  parameter int unsigned TIMEOUT_CYCLES       = 32'd3_000_000_000,
  parameter int unsigned SHUTDOWN_CYCLES      = 25_000_000,
  parameter int unsigned SYNC_STAGES          = 2,
  parameter logic        IDLE_LEVEL           = 1'b1,
  parameter bit          SHUTDOWN_ACTIVE_HIGH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_line_i,
  input  logic rx_line_i,
  output logic tx_active_o,
  output logic rx_active_o,
  output logic shutdown_o
);
  import lw_pkg::*;

  logic [NUM_LINES-1:0] line_in, line_edge, line_act, line_exp;
  logic                 sd_busy;

  assign line_in[LINE_TX] = tx_line_i;
  assign line_in[LINE_RX] = rx_line_i;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    lw_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(IDLE_LEVEL)) u_sync (
      .clk_i (clk_i), .rst_ni(rst_ni), .line_i(line_in[l]), .edge_o(line_edge[l])
    );
    lw_retrig_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
      .clk_i (clk_i), .rst_ni(rst_ni), .edge_i(line_edge[l]),
      .active_o(line_act[l]), .expire_o(line_exp[l])
    );
  end

  lw_oneshot #(.PULSE_CYCLES(SHUTDOWN_CYCLES)) u_shut (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(|line_exp), .busy_o(sd_busy)
  );

  assign tx_active_o = line_act[LINE_TX];
  assign rx_active_o = line_act[LINE_RX];
  assign shutdown_o  = SHUTDOWN_ACTIVE_HIGH ? sd_busy : ~sd_busy;

  // R8
  pulse_after_activity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_busy) |-> $past(|line_act, 2));
endmodule

// File: tb/line_activity_watchdog_test.sv
module line_activity_watchdog_test;
  localparam int T    = 20;
  localparam int S    = 12;
  localparam int NCYC = 3600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx = 1'b1, rx = 1'b1;
  logic tx_act, rx_act, sd;
  logic tx_act_i, rx_act_i, sd_i;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  line_activity_watchdog #(.TIMEOUT_CYCLES(T), .SHUTDOWN_CYCLES(S)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tx_line_i(tx), .rx_line_i(rx),
    .tx_active_o(tx_act), .rx_active_o(rx_act), .shutdown_o(sd)
  );

  line_activity_watchdog #(.TIMEOUT_CYCLES(T), .SHUTDOWN_CYCLES(S),
                           .SHUTDOWN_ACTIVE_HIGH(1'b0)) uut_inv (
    .clk_i(clk), .rst_ni(rst_n), .tx_line_i(tx), .rx_line_i(rx),
    .tx_active_o(tx_act_i), .rx_active_o(rx_act_i), .shutdown_o(sd_i)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at time %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  // toggle mask per 300-cycle segment: toggle when (lfsr & mask)==0; 16'hFFFF = silent
  function automatic logic [15:0] seg_mask(input int seg, input int line);
    case (seg % 6)
      0: return 16'hFFFF;
      1: return line == 0 ? 16'h0001 : 16'hFFFF;
      2: return 16'h0007;
      3: return 16'h001F;
      4: return line == 0 ? 16'h000F : 16'h003F;
      default: return 16'h007F;
    endcase
  endfunction

  bit tg [2][NCYC];

  initial begin
    logic [15:0] lf [2];
    int  det [2];
    bit  det_v [2];
    bit  exp_act [2];
    bit  prev_act [2];
    bit  have_p;
    int  pstart;
    bit  exp_sd, any_fall;
    lf[0] = 16'hACE1; lf[1] = 16'h1D35;
    for (int l = 0; l < 2; l++) begin det[l] = 0; det_v[l] = 0; prev_act[l] = 0; end
    have_p = 0; pstart = 0;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx_active", tx_act, 1'b0);
    chk("R1 rx_active", rx_act, 1'b0);
    chk("R1 shutdown", sd, 1'b0);
    chk("R1 shutdown inverted", sd_i, 1'b1);
    rst_n = 1'b1;

    for (int m = 0; m < NCYC; m++) begin
      @(posedge clk);
      @(negedge clk);
      any_fall = 0;
      for (int l = 0; l < 2; l++) begin
        if (m >= 3 && tg[l][m-3]) begin det_v[l] = 1; det[l] = m; end
        exp_act[l] = det_v[l] && (m - det[l] < T);
        if (prev_act[l] && !exp_act[l]) any_fall = 1;
        prev_act[l] = exp_act[l];
      end
      exp_sd = have_p && m >= pstart && m < pstart + S;
      if (any_fall && (!have_p || m >= pstart + S)) begin
        have_p = 1; pstart = m + 1;
      end
      // R2 R3 R4 R5 activity flags
      chk("R2/R3/R4/R5 tx_active", tx_act, exp_act[0]);
      chk("R2/R3/R4/R5 rx_active", rx_act, exp_act[1]);
      // R6 R7 R8 shutdown pulse
      chk(m < 300 ? "R8 shutdown idle" : "R6/R7 shutdown", sd, exp_sd);
      // R9 inverted polarity
      chk("R9 shutdown inverted", sd_i, ~exp_sd);
      for (int l = 0; l < 2; l++) begin
        lf[l] = lfsr_next(lf[l]);
        tg[l][m] = ((lf[l] & seg_mask(m / 300, l)) == 16'h0) && (m < NCYC - 4);
      end
      if (tg[0][m]) tx = ~tx;
      if (tg[1][m]) rx = ~rx;
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule